// File: doc/BRIEF.md
# Serial Attenuator Control Receiver

This block is the digital control front end of a single-channel volume attenuator. A host drives three wires: a serial data line, a serial clock and an active-low load strobe. While the strobe is low, each rising edge of the serial clock shifts one data bit into a frame register. When the strobe rises, the block checks that exactly sixteen bits arrived and that the leading byte selects the one channel. If both hold, the block commits the trailing byte as the new attenuation setting.

The committed setting is decoded into three outputs. The first is an attenuation value in whole dB. The second is a mute flag. The third is a 64-wide one-hot select that drives the analog switch ladder. All three serial inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and edges are detected in the system domain. The block leaves reset muted.

Top module: `sat_rx`

## Requirements
- R1: A frame is 16 bits, sent most significant bit first: an 8-bit channel byte followed by an 8-bit setting byte. A bit is shifted in only on a rising serial-clock edge while the strobe is low.
- R2: On a strobe rising edge, the frame commits when exactly 16 bits were shifted and the channel byte equals 8'h00.
- R3: A frame whose channel byte is not 8'h00 is discarded, and all outputs keep their values.
- R4: A frame with any bit count other than 16 (for example 15 or 17) is discarded, and all outputs keep their values.
- R5: A committed setting code of 0 to 62 gives `atten_db_o` equal to the code and `mute_o` = 0.
- R6: A committed setting code of 63 to 255 gives `atten_db_o` = 96 and `mute_o` = 1.
- R7: `sw_sel_o` has exactly one bit set. That bit is at index equal to the code for codes 0 to 62, and at index 63 when muted.
- R8: After reset, `atten_db_o` = 96, `mute_o` = 1 and `sw_sel_o` has bit 63 set.
- R9: All three outputs change together in one system cycle, and they hold between commits.
- R10: A serial-clock rising edge is ignored if it is seen in the same synchronized cycle as the strobe rising edge, or while the strobe is high.
- R11: When the strobe rises half a cycle before a system clock edge, the new outputs appear after the third rising system clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| load_ni | input | 1 | Active-low load strobe, asynchronous |
| atten_db_o | output | 7 | Attenuation in dB (96 when muted) |
| mute_o | output | 1 | Mute flag |
| sw_sel_o | output | 64 | One-hot switch select |

## Verification
The strobe's rising edge and a serial-clock rising edge can reach the synchronized domain in the same cycle. In that case the edge detector has to drop the clock edge and must not count it as a seventeenth bit. The bench provokes this by switching both wires at the same moment after a complete 16-bit frame. It then expects the frame to commit with its sixteen bits intact. It also raises the strobe on frames of 15 and 17 bits, and it expects no change on any output in any cycle.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned SET_W    = 8;
  localparam int unsigned DB_W     = 7;
  localparam int unsigned SEL_N    = 64;
  localparam int unsigned MAX_CODE = 62;
  localparam int unsigned MUTE_DB  = 96;
endpackage

// File: rtl/sat_sync.sv
module sat_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] rst_val_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic ff1_q, ff2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q <= rst_val_i[g];
        ff2_q <= rst_val_i[g];
      end else begin
        ff1_q <= d_i[g];
        ff2_q <= ff1_q;
      end
    end
    assign q_o[g] = ff2_q;
  end
endmodule

// File: rtl/sat_frame.sv
module sat_frame
  import sat_pkg::*;
#(
  parameter int unsigned A_W = ADDR_W,
  parameter int unsigned S_W = SET_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sdata_i,
  input  logic           sclk_i,
  input  logic           load_ni,
  output logic           commit_o,
  output logic [S_W-1:0] code_o
);
  localparam int unsigned FRAME_W = A_W + S_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sclk_q, load_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sclk_rise, load_rise, shift_en;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign load_rise = load_ni & ~load_q;
  // strobe must still be low in the sampled cycle
  assign shift_en  = sclk_rise & ~load_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      load_q  <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      load_q <= load_ni;
      if (load_rise) begin
        cnt_q <= '0;
      end else if (shift_en) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], sdata_i};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign commit_o = load_rise && (cnt_q == CNT_FULL) && (shreg_q[FRAME_W-1:S_W] == '0);
  assign code_o   = shreg_q[S_W-1:0];

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OVER);

  // R10
  no_shift_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni && !load_rise |=> $stable(cnt_q));
endmodule

// File: rtl/sat_decode.sv
module sat_decode
  import sat_pkg::*;
#(
  parameter int unsigned S_W  = SET_W,
  parameter int unsigned D_W  = DB_W,
  parameter int unsigned N    = SEL_N,
  parameter int unsigned MAXC = MAX_CODE,
  parameter int unsigned MDB  = MUTE_DB
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           commit_i,
  input  logic [S_W-1:0] code_i,
  output logic [D_W-1:0] atten_db_o,
  output logic           mute_o,
  output logic [N-1:0]   sw_sel_o
);
  localparam int unsigned SEL_W = $clog2(N);
  localparam logic [SEL_W-1:0] MUTE_IDX = SEL_W'(N - 1);

  logic             in_range;
  logic [SEL_W-1:0] idx;

  assign in_range = (32'(code_i) <= MAXC);
  assign idx      = in_range ? SEL_W'(code_i) : MUTE_IDX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      atten_db_o <= D_W'(MDB);
      mute_o     <= 1'b1;
      sw_sel_o   <= N'(1) << MUTE_IDX;
    end else if (commit_i) begin
      atten_db_o <= in_range ? D_W'(code_i) : D_W'(MDB);
      mute_o     <= ~in_range;
      sw_sel_o   <= N'(1) << idx;
    end
  end

  // R7
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sw_sel_o) == 1);

  // R6
  mute_db_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> (32'(atten_db_o) == MDB) && sw_sel_o[N-1]);
endmodule

// File: rtl/sat_rx.sv
module sat_rx
  import sat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             sclk_i,
  input  logic             load_ni,
  output logic [DB_W-1:0]  atten_db_o,
  output logic             mute_o,
  output logic [SEL_N-1:0] sw_sel_o
);
  logic [2:0]       raw, synced;
  logic             commit;
  logic [SET_W-1:0] code;

  assign raw = {load_ni, sclk_i, sdata_i};

  sat_sync #(.WIDTH(3)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       (raw),
    .rst_val_i (3'b100),
    .q_o       (synced)
  );

  sat_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sdata_i  (synced[0]),
    .sclk_i   (synced[1]),
    .load_ni  (synced[2]),
    .commit_o (commit),
    .code_o   (code)
  );

  sat_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .code_i     (code),
    .atten_db_o (atten_db_o),
    .mute_o     (mute_o),
    .sw_sel_o   (sw_sel_o)
  );

  // R9
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(atten_db_o) && $stable(mute_o) && $stable(sw_sel_o));

  // R5
  db_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mute_o |-> atten_db_o <= DB_W'(MAX_CODE));
endmodule

// File: tb/sat_rx_tb.sv
module sat_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, load_n = 1'b1;
  logic [6:0]  atten_db;
  logic        mute;
  logic [63:0] sw_sel;

  int checks = 0, errors = 0;
  bit settled = 1'b0;
  bit done = 1'b0;
  string tag = "R8";
  int exp_db = 96;
  bit exp_mute = 1'b1;
  int exp_idx = 63;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk),
    .load_ni(load_n), .atten_db_o(atten_db), .mute_o(mute), .sw_sel_o(sw_sel)
  );

  function automatic bit outs_match();
    return (int'(atten_db) == exp_db) && (mute == exp_mute) &&
           (sw_sel == (64'd1 << exp_idx));
  endfunction

  task automatic check_now(string t);
    checks++;
    if (!outs_match()) begin
      errors++;
      $display("FAIL %s: got db=%0d mute=%0b sel=%h exp db=%0d mute=%0b sel=%h",
               t, atten_db, mute, sw_sel, exp_db, exp_mute, 64'd1 << exp_idx);
    end
  endtask

  // every-clock comparison against the model while no commit is pending
  always @(negedge clk) if (settled && rst_n && !done) check_now(tag);

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // model: expected result of committing setting c
  task automatic model_commit(int c);
    if (c <= 62) begin exp_db = c; exp_mute = 1'b0; exp_idx = c; end
    else begin exp_db = 96; exp_mute = 1'b1; exp_idx = 63; end
  endtask

  // send nbits of word (MSB of the nbits first); coincide: final strobe rise with a clock edge
  task automatic send(int nbits, logic [31:0] word, bit coincide, string t);
    bit commits;
    int old_db, old_idx;
    bit old_mute;
    tag = t;
    commits = (nbits == 16) && (word[15:8] == 8'h00);
    @(negedge clk);
    load_n = 1'b0;
    wait_clk(HOLD);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = word[i];
      sclk = 1'b0; wait_clk(HOLD);
      sclk = 1'b1; wait_clk(HOLD);
    end
    sclk = 1'b0;
    wait_clk(HOLD);
    if (commits) begin
      settled = 1'b0;
      old_db = exp_db; old_mute = exp_mute; old_idx = exp_idx;
      if (coincide) sclk = 1'b1;
      load_n = 1'b1;
      wait_clk(2);
      check_now({t, "/R11 before"});
      model_commit(int'(word[7:0]));
      wait_clk(1);
      check_now({t, "/R11 after"});
      if (old_db == exp_db && old_mute == exp_mute && old_idx == exp_idx) ;
      settled = 1'b1;
    end else begin
      if (coincide) sclk = 1'b1;
      load_n = 1'b1;
    end
    wait_clk(HOLD);
    sclk = 1'b0;
    wait_clk(HOLD);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
    check_now("R8 reset");
    settled = 1'b1;
    wait_clk(4);
    // R1 R2 R5: basic in-range settings, MSB first
    send(16, 32'h0000, 1'b0, "R5 code0");
    send(16, 32'h0005, 1'b0, "R1 code5");
    send(16, 32'h003E, 1'b0, "R5 code62");
    send(16, 32'h0021, 1'b0, "R2 code33");
    // R6 R7: mute range
    send(16, 32'h003F, 1'b0, "R6 code63");
    send(16, 32'h0011, 1'b0, "R7 code17");
    send(16, 32'h00FF, 1'b0, "R6 code255");
    send(16, 32'h0040, 1'b0, "R6 code64");
    send(16, 32'h002A, 1'b0, "R7 code42");
    // R3: nonzero channel byte
    send(16, 32'h0103, 1'b0, "R3 addr01");
    send(16, 32'h8007, 1'b0, "R3 addr80");
    // R4: wrong counts
    send(15, 32'h0009, 1'b0, "R4 15bits");
    send(17, 32'h0000B, 1'b0, "R4 17bits");
    send(0, 32'h0, 1'b0, "R4 0bits");
    // R10: clock edge together with strobe rise
    send(16, 32'h0013, 1'b1, "R10 coincide");
    // R10: clock pulses while strobe high
    tag = "R10 idle clocks";
    for (int k = 0; k < 5; k++) begin
      sdata = 1'b1; sclk = 1'b1; wait_clk(HOLD);
      sclk = 1'b0; wait_clk(HOLD);
    end
    send(16, 32'h0001, 1'b0, "R10 after idle");
    // R9: back-to-back commits
    send(16, 32'h0000, 1'b0, "R9 zero");
    send(16, 32'h0080, 1'b0, "R9 mute");
    wait_clk(10);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule